// File: doc/BRIEF.md
# Boundary-Scan Register Cell Chain

This block is a chain of boundary-scan cells placed between a device's core logic and its signal pins. Each cell sits on one functional path. For an input cell that path runs from the pin to the core. For an output cell it runs from the core to the pin. Every cell has two stages: a shift stage that captures and shifts serial test data, and an update stage that holds a value steady for the functional side. Power and ground pins have no cell.

The test access port controller drives the chain. It supplies capture, shift and update strobes that act as clock enables on the test clock, together with a two-bit mode select.

- In normal mode the cells are transparent and ignore the strobes.
- In sample/preload mode the chain can be captured, shifted and updated while the functional paths stay transparent. This lets test data be loaded ahead of time.
- In external-test mode the update stages drive the functional outputs. This puts the preloaded pattern on the pins and on the core inputs.

Input cells occupy chain positions 0 to NUM_IN-1 and output cells occupy the positions above them. Position 0 is nearest the serial output.

Top module: `bscan_chain`

## Requirements
- R1: After reset every shift stage and every update stage is 0. An external-test selection made straight after reset therefore drives 0 on pin_out_o and core_in_o, and shifting out reads back zeros.
- R2: With mode 2'b00 (normal) or 2'b01 (sample/preload), core_in_o equals pin_in_i and pin_out_o equals core_out_i, whatever the update stages hold.
- R3: With mode 2'b10 (external test), core_in_o[i] is the update stage of cell i and pin_out_o[j] is the update stage of cell NUM_IN+j.
- R4: A capture strobe in mode 2'b01 or 2'b10 loads cell i with pin_in_i[i] for i < NUM_IN and cell NUM_IN+j with core_out_i[j]. After that edge tdo_o shows cell 0.
- R5: Each edge with the shift strobe active, in mode 2'b01 or 2'b10, moves every shift stage one place toward cell 0, and tdi_i enters cell N-1. tdo_o is always cell 0's shift stage. After k shifts it shows the value that was captured in cell k. The bit applied at shift step j (counting from 0) rests in cell j after N shifts.
- R6: The update stages load from the shift stages only on an edge with the update strobe active in mode 2'b01 or 2'b10. They hold through later shifts and captures, so the external-test outputs stay steady during a scan.
- R7: When shift and update strobes fall on the same edge, the update stages take the shift-stage contents from before that shift.
- R8: When capture and shift strobes fall on the same edge, the shift wins and the capture is dropped.
- R9: In mode 2'b00 or the reserved mode 2'b11, all three strobes are ignored and both stages keep their values. Mode 2'b11 is functionally transparent, like normal mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Test clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | 00 normal, 01 sample/preload, 10 external test, 11 reserved (normal) |
| capture_i | input | 1 | Capture strobe |
| shift_i | input | 1 | Shift strobe |
| update_i | input | 1 | Update strobe |
| tdi_i | input | 1 | Serial data into cell N-1 |
| tdo_o | output | 1 | Serial data from cell 0 |
| pin_in_i | input | NUM_IN | Values arriving at the input pins |
| core_in_o | output | NUM_IN | Values delivered to the core inputs |
| core_out_i | input | NUM_OUT | Values produced by the core outputs |
| pin_out_o | output | NUM_OUT | Values driven toward the output pins |

## Verification
Two functions can fall on the same test-clock edge: shift with update, and shift with capture. The bench provokes the first by asserting the shift and update strobes together after a known pattern has been shifted in. It judges the result by the external-test outputs, which must show the pattern from before the shift, and by tdo_o, which must show the pattern moved one place. The second is provoked by asserting capture and shift together while pin_in_i[0] differs from the bit in cell 1. tdo_o must then carry cell 1's old bit rather than the pin value.

// File: rtl/bscan_pkg.sv
package bscan_pkg;
  typedef enum logic [1:0] {
    BS_NORMAL = 2'b00,
    BS_SAMPLE = 2'b01,
    BS_EXTEST = 2'b10,
    BS_RSVD   = 2'b11
  } bs_mode_e;
endpackage

// File: rtl/bscan_ctrl.sv
module bscan_ctrl
  import bscan_pkg::*;
(
  input  logic [1:0] mode_i,
  input  logic       capture_i,
  input  logic       shift_i,
  input  logic       update_i,
  output logic       cap_en_o,
  output logic       shf_en_o,
  output logic       upd_en_o,
  output logic       drive_en_o
);
  bs_mode_e mode;
  logic     active;

  always_comb begin
    mode       = bs_mode_e'(mode_i);
    active     = 1'b0;
    drive_en_o = 1'b0;
    case (mode)
      BS_SAMPLE: active = 1'b1;
      BS_EXTEST: begin
        active     = 1'b1;
        drive_en_o = 1'b1;
      end
      default: ;
    endcase
  end

  // shift takes priority over capture
  assign shf_en_o = active & shift_i;
  assign cap_en_o = active & capture_i & ~shift_i;
  assign upd_en_o = active & update_i;
endmodule

// File: rtl/bscan_cell.sv
module bscan_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cap_en_i,
  input  logic shf_en_i,
  input  logic upd_en_i,
  input  logic drive_en_i,
  input  logic ser_i,
  input  logic par_i,
  output logic par_o,
  output logic ser_o,
  output logic hold_o
);
  logic shf_q, upd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       shf_q <= 1'b0;
    else if (shf_en_i) shf_q <= ser_i;
    else if (cap_en_i) shf_q <= par_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       upd_q <= 1'b0;
    else if (upd_en_i) upd_q <= shf_q;
  end

  assign par_o  = drive_en_i ? upd_q : par_i;
  assign ser_o  = shf_q;
  assign hold_o = upd_q;
endmodule

// File: rtl/bscan_chain.sv
module bscan_chain #(
  parameter int unsigned NUM_IN  = 4,
  parameter int unsigned NUM_OUT = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [1:0]         mode_i,
  input  logic               capture_i,
  input  logic               shift_i,
  input  logic               update_i,
  input  logic               tdi_i,
  output logic               tdo_o,
  input  logic [NUM_IN-1:0]  pin_in_i,
  output logic [NUM_IN-1:0]  core_in_o,
  input  logic [NUM_OUT-1:0] core_out_i,
  output logic [NUM_OUT-1:0] pin_out_o
);
  localparam int unsigned N = NUM_IN + NUM_OUT;

  logic         cap_en, shf_en, upd_en, drive_en;
  logic [N-1:0] par_in, par_out, ser_in, shf_q, upd_q;

  bscan_ctrl i_ctrl (
    .mode_i     (mode_i),
    .capture_i  (capture_i),
    .shift_i    (shift_i),
    .update_i   (update_i),
    .cap_en_o   (cap_en),
    .shf_en_o   (shf_en),
    .upd_en_o   (upd_en),
    .drive_en_o (drive_en)
  );

  for (genvar i = 0; i < N; i++) begin : g_cell
    if (i < NUM_IN) begin : g_in
      assign par_in[i]    = pin_in_i[i];
      assign core_in_o[i] = par_out[i];
    end else begin : g_out
      assign par_in[i]             = core_out_i[i-NUM_IN];
      assign pin_out_o[i-NUM_IN]   = par_out[i];
    end

    if (i == N-1) begin : g_head
      assign ser_in[i] = tdi_i;
    end else begin : g_link
      assign ser_in[i] = shf_q[i+1];
    end

    bscan_cell i_cell (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .cap_en_i   (cap_en),
      .shf_en_i   (shf_en),
      .upd_en_i   (upd_en),
      .drive_en_i (drive_en),
      .ser_i      (ser_in[i]),
      .par_i      (par_in[i]),
      .par_o      (par_out[i]),
      .ser_o      (shf_q[i]),
      .hold_o     (upd_q[i])
    );
  end

  assign tdo_o = shf_q[0];
endmodule

// File: rtl/bscan_chain_chk.sv
module bscan_chain_chk #(
  parameter int unsigned NUM_IN  = 4,
  parameter int unsigned NUM_OUT = 4
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic [1:0]                mode_i,
  input logic                      capture_i,
  input logic                      shift_i,
  input logic                      update_i,
  input logic                      tdo_o,
  input logic [NUM_IN-1:0]         pin_in_i,
  input logic [NUM_OUT-1:0]        pin_out_o,
  input logic [NUM_IN+NUM_OUT-1:0] shf_q,
  input logic [NUM_IN+NUM_OUT-1:0] upd_q
);
  logic act;
  assign act = (mode_i == 2'b01) || (mode_i == 2'b10);

  AST_UPD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(act && update_i) |=> $stable(upd_q)); // R6

  AST_UPD_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act && update_i) |=> (upd_q == $past(shf_q))); // R7

  AST_SHIFT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act && shift_i) |=> (tdo_o == $past(shf_q[1]))); // R5

  AST_CAPTURE_PIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act && capture_i && !shift_i) |=> (tdo_o == $past(pin_in_i[0]))); // R4

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act |=> ($stable(shf_q) && $stable(upd_q))); // R9

  AST_EXTEST_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b10) |-> (pin_out_o == upd_q[NUM_IN+NUM_OUT-1:NUM_IN])); // R3
endmodule

bind bscan_chain bscan_chain_chk #(.NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT)) i_chk (.*);

// File: tb/test_bscan_chain.sv
module test_bscan_chain;
  localparam int CLK_PERIOD = 10;
  localparam int NI = 4;
  localparam int NO = 4;
  localparam int N  = NI + NO;
  // {pin_in, core_out, shift word}
  localparam logic [15:0] VEC [6] = '{
    16'hA5_3C, 16'h0F_FF, 16'hF0_00, 16'h69_81, 16'h12_7E, 16'hC3_A5
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic [1:0]    mode;
  logic          cap, shf, upd, tdi;
  logic [NI-1:0] pin_in, core_in;
  logic [NO-1:0] core_out, pin_out;
  logic          tdo;
  int            checks = 0;
  int            errors = 0;
  bit            done = 1'b0;
  logic [N-1:0]  got;
  bit            steady;

  always #(CLK_PERIOD/2) clk = ~clk;

  bscan_chain #(.NUM_IN(NI), .NUM_OUT(NO)) i_bscan_chain (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .capture_i(cap),
    .shift_i(shf), .update_i(upd), .tdi_i(tdi), .tdo_o(tdo),
    .pin_in_i(pin_in), .core_in_o(core_in),
    .core_out_i(core_out), .pin_out_o(pin_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic do_capture();
    cap = 1'b1; @(negedge clk); cap = 1'b0;
  endtask

  task automatic do_update();
    upd = 1'b1; @(negedge clk); upd = 1'b0;
  endtask

  task automatic shift_word(input logic [N-1:0] w, output logic [N-1:0] g);
    for (int k = 0; k < N; k++) begin
      tdi = w[k];
      g[k] = tdo;
      shf = 1'b1;
      @(negedge clk);
    end
    shf = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    rst_n = 1'b0; mode = 2'b00; cap = 0; shf = 0; upd = 0; tdi = 0;
    pin_in = '0; core_out = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    pin_in = 4'hA; core_out = 4'h5; #1;
    check("R1/R2 normal core_in", core_in, 4'hA);
    check("R1/R2 normal pin_out", pin_out, 4'h5);
    mode = 2'b10; #1;
    check("R1 extest pin_out", pin_out, 0);
    check("R1 extest core_in", core_in, 0);
    @(negedge clk);
    mode = 2'b01;
    shift_word('0, got);
    check("R1 shift stages zero", got, 0);

    // vector walk
    foreach (VEC[v]) begin
      mode = 2'b01;
      pin_in = VEC[v][15:12]; core_out = VEC[v][11:8]; #1;
      check("R2 sample core_in", core_in, VEC[v][15:12]);
      check("R2 sample pin_out", pin_out, VEC[v][11:8]);
      @(negedge clk);
      do_capture();
      check("R4 tdo after capture", tdo, VEC[v][12]);
      shift_word(VEC[v][7:0], got);
      check("R4/R5 captured image", got, {VEC[v][11:8], VEC[v][15:12]});
      do_update();
      mode = 2'b10; #1;
      check("R3/R6 extest pin_out", pin_out, VEC[v][7:4]);
      check("R3/R6 extest core_in", core_in, VEC[v][3:0]);
      @(negedge clk);
      mode = 2'b01;
      shift_word('0, got);
      check("R5 shifted-in word", got, VEC[v][7:0]);
    end

    // R6 hold during scan
    mode = 2'b01;
    shift_word(8'h3C, got);
    do_update();
    mode = 2'b10;
    steady = 1'b1;
    for (int k = 0; k < N; k++) begin
      tdi = 1'b1; shf = 1'b1;
      @(negedge clk);
      if (pin_out !== 4'h3 || core_in !== 4'hC) steady = 1'b0;
    end
    shf = 1'b0;
    pin_in = 4'h0; core_out = 4'hF;
    do_capture();
    if (pin_out !== 4'h3 || core_in !== 4'hC) steady = 1'b0;
    check("R6 update stage holds", steady, 1);

    // R7 shift and update on the same edge
    mode = 2'b01;
    shift_word(8'h96, got);
    tdi = 1'b1; shf = 1'b1; upd = 1'b1;
    @(negedge clk);
    shf = 1'b0; upd = 1'b0;
    check("R7 tdo moved", tdo, 1);
    mode = 2'b10; #1;
    check("R7 pin_out pre-shift", pin_out, 4'h9);
    check("R7 core_in pre-shift", core_in, 4'h6);
    @(negedge clk);

    // R8 capture and shift on the same edge
    mode = 2'b01;
    shift_word(8'h96, got);
    pin_in = 4'h0; tdi = 1'b0; cap = 1'b1; shf = 1'b1;
    @(negedge clk);
    cap = 1'b0; shf = 1'b0;
    check("R8 shift wins", tdo, 1);

    // R9 strobes ignored in normal and reserved modes
    shift_word(8'h5A, got);
    do_update();
    mode = 2'b00;
    shift_word(8'hFF, got);
    pin_in = 4'hF; core_out = 4'hF;
    do_capture();
    do_update();
    mode = 2'b11;
    shift_word(8'h00, got);
    do_capture();
    do_update();
    pin_in = 4'h3; core_out = 4'h9; #1;
    check("R9 reserved mode core_in", core_in, 4'h3);
    check("R9 reserved mode pin_out", pin_out, 4'h9);
    mode = 2'b10; #1;
    check("R9 update kept pin_out", pin_out, 4'h5);
    check("R9 update kept core_in", core_in, 4'hA);
    @(negedge clk);
    mode = 2'b01;
    shift_word('0, got);
    check("R9 shift stages kept", got, 8'h5A);

    report();
  end
endmodule